// File: doc/BRIEF.md
# Paged ROM Table Lookup Unit

This unit carries out table reads for a small 4-bit controller core. A read command brings a 7-bit page number. The unit joins that page with a 3-bit pointer register D and the accumulator A to form a ROM address, and issues one read on a synchronous ROM port. When the 10-bit word returns, its low nibble is written to A and its middle nibble to B. A mode flag decides what happens to the top two bits. When the flag is set, they are written into D, with the top bit of D cleared. When the flag is clear, they are discarded and D keeps its value.

The unit owns D and the mode flag. Separate commands set the flag, clear the flag, and load D directly. A and B belong to the surrounding datapath: the unit reads A through `acc_in` and requests writes to A and B through write-enable and write-data pins. The ROM returns data one cycle after the read strobe. During that cycle `busy` is high, and while `busy` is high every command is dropped. A one-cycle `done` pulse marks the cycle in which A, B and D all hold their new contents.

Reset is asynchronous and active-low. Its release passes through a two-stage synchronizer. D is not reset and must be loaded before it is used.

Top module: `tblrd_unit`

## Requirements
- R1: In the cycle a read command is taken, `rom_rd` is 1 and `rom_addr` equals {cmd_page[6:0], D[2:0], acc_in[3:0]}, with the page in the top bits.
- R2: `rom_rd` pulses for exactly the cycle a read is taken, and `busy` is 1 for exactly the following cycle.
- R3: In the busy cycle `a_we` and `b_we` are 1, `a_wdata` equals rom_data[3:0] and `b_wdata` equals rom_data[7:4]. In every other cycle both enables are 0.
- R4: `done` is 1 for one cycle, the cycle after busy. In that cycle `d_q` already shows the result of the read.
- R5: When the mode flag is 1, a read leaves D = {1'b0, rom_data[9:8]}.
- R6: When the mode flag is 0, a read leaves D unchanged.
- R7: `cmd_op` encodings are 0 = no-op, 1 = table read, 2 = set mode flag, 3 = clear mode flag, 4 = load D. A taken set or clear command changes `mode_q` on the next cycle.
- R8: A taken load command makes `d_q` equal `cmd_ptr` on the next cycle.
- R9: Any command that arrives while `busy` is 1 is ignored. A read starts no ROM access and produces no extra done pulse, and a set or clear leaves `mode_q` unchanged.
- R10: After reset, `busy`, `done`, `rom_rd`, `a_we`, `b_we` and `mode_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R7) |
| cmd_page | input | 7 | Page number for a table read |
| cmd_ptr | input | 3 | Value for a D load |
| acc_in | input | 4 | Current accumulator A |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 14 | ROM word address |
| rom_data | input | 10 | ROM word, valid one cycle after `rom_rd` |
| busy | output | 1 | Read in flight; commands are ignored |
| done | output | 1 | A, B and D updated |
| a_we | output | 1 | Write enable for A |
| a_wdata | output | 4 | Data for A |
| b_we | output | 1 | Write enable for B |
| b_wdata | output | 4 | Data for B |
| d_q | output | 3 | Pointer register D |
| mode_q | output | 1 | Mode flag |

## Verification
The hardest case to reach is a read issued the cycle after a previous read, or any command that lands exactly in the busy cycle. Either one needs stimulus that is aligned to a single cycle. The bench drives a second command in the busy cycle of a read and checks that it is dropped. It also chains reads so that each one follows the previous one as early as allowed, which makes the next address depend on the A and D values written by the read just before.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_READ = 3'd1,
    OP_MSET = 3'd2,
    OP_MCLR = 3'd3,
    OP_LOAD = 3'd4
  } tbl_op_e;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
  parameter int PAGE_W = 7,
  parameter int PTR_W  = 3,
  parameter int ACC_W  = 4,
  localparam int ADDR_W = PAGE_W + PTR_W + ACC_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [ACC_W-1:0]  acc,
  output logic [ADDR_W-1:0] addr
);
  // page selects the block, pointer and accumulator index inside it
  always_comb begin
    addr = {page, ptr, acc};
  end
endmodule

// File: rtl/tblrd_word_split.sv
module tblrd_word_split #(
  parameter int WORD_W = 10,
  parameter int ACC_W  = 4,
  localparam int HI_W = WORD_W - 2 * ACC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [ACC_W-1:0]  lo,
  output logic [ACC_W-1:0]  mid,
  output logic [HI_W-1:0]   hi
);
  always_comb begin
    lo  = word[ACC_W-1:0];
    mid = word[2*ACC_W-1:ACC_W];
    hi  = word[WORD_W-1:2*ACC_W];
  end
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  output logic busy,
  output logic done
);
  logic busy_q, busy_d;
  logic done_q, done_d;

  always_comb begin
    busy_d = rd_start & ~busy_q;
    done_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/tblrd_ptr_reg.sv
module tblrd_ptr_reg #(
  parameter int PTR_W = 3,
  parameter int HI_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_set,
  input  logic             mode_clr,
  input  logic             ld_en,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             tbl_wr,
  input  logic [HI_W-1:0]  tbl_hi,
  output logic [PTR_W-1:0] d_q,
  output logic             mode_q
);
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_from_tbl;
  logic             ptr_en;
  logic             mode_r, mode_d, mode_en;

  // upper pointer bits not covered by the word are cleared
  generate
    if (HI_W < PTR_W) begin : g_zext
      assign ptr_from_tbl = {{(PTR_W-HI_W){1'b0}}, tbl_hi};
    end else begin : g_trunc
      assign ptr_from_tbl = tbl_hi[PTR_W-1:0];
    end
  endgenerate

  always_comb begin
    ptr_en = tbl_wr | ld_en;
    ptr_d  = tbl_wr ? ptr_from_tbl : ld_val;
    mode_en = mode_set | mode_clr;
    mode_d  = mode_set;
  end

  // pointer has no reset value; software loads it
  always_ff @(posedge clk) begin
    if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= 1'b0;
    end else if (mode_en) begin
      mode_r <= mode_d;
    end
  end

  assign d_q    = ptr_q;
  assign mode_q = mode_r;
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int PTR_W  = 3,
  parameter int ACC_W  = 4,
  parameter int WORD_W = 10,
  localparam int ADDR_W = PAGE_W + PTR_W + ACC_W,
  localparam int HI_W   = WORD_W - 2 * ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [ACC_W-1:0]  acc_in,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  output logic              busy,
  output logic              done,
  output logic              a_we,
  output logic [ACC_W-1:0]  a_wdata,
  output logic              b_we,
  output logic [ACC_W-1:0]  b_wdata,
  output logic [PTR_W-1:0]  d_q,
  output logic              mode_q
);
  // reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  tbl_op_e         op;
  logic            cmd_take, rd_start, mode_set, mode_clr, ld_en, tbl_wr;
  logic [ACC_W-1:0] w_lo, w_mid;
  logic [HI_W-1:0]  w_hi;

  always_comb begin
    op       = tbl_op_e'(cmd_op);
    cmd_take = cmd_valid & rst_int_n & ~busy;
    rd_start = cmd_take & (op == OP_READ);
    mode_set = cmd_take & (op == OP_MSET);
    mode_clr = cmd_take & (op == OP_MCLR);
    ld_en    = cmd_take & (op == OP_LOAD);
    tbl_wr   = busy & mode_q;
  end

  tblrd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_start (rd_start),
    .busy     (busy),
    .done     (done)
  );

  tblrd_addr_gen #(.PAGE_W(PAGE_W), .PTR_W(PTR_W), .ACC_W(ACC_W)) u_addr (
    .page (cmd_page),
    .ptr  (d_q),
    .acc  (acc_in),
    .addr (rom_addr)
  );

  tblrd_word_split #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_split (
    .word (rom_data),
    .lo   (w_lo),
    .mid  (w_mid),
    .hi   (w_hi)
  );

  tblrd_ptr_reg #(.PTR_W(PTR_W), .HI_W(HI_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_set (mode_set),
    .mode_clr (mode_clr),
    .ld_en    (ld_en),
    .ld_val   (cmd_ptr),
    .tbl_wr   (tbl_wr),
    .tbl_hi   (w_hi),
    .d_q      (d_q),
    .mode_q   (mode_q)
  );

  always_comb begin
    rom_rd  = rd_start;
    a_we    = busy;
    b_we    = busy;
    a_wdata = w_lo;
    b_wdata = w_mid;
  end
endmodule

// File: rtl/tblrd_unit_chk.sv
module tblrd_unit_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [PTR_W-1:0] cmd_ptr,
  input logic             rom_rd,
  input logic             busy,
  input logic             done,
  input logic             a_we,
  input logic             b_we,
  input logic [PTR_W-1:0] d_q,
  input logic             mode_q
);
  // R2
  busy_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> busy);
  // R2
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R9
  no_rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rom_rd);
  // R3
  we_match_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we == busy) && (b_we == busy));
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |=> $stable(d_q));
  // R5
  ptr_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |=> (d_q[PTR_W-1] == 1'b0));
  // R8
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4 && !busy) |=> (d_q == $past(cmd_ptr)));
  // R7
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !busy) |=> mode_q);
  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
endmodule

bind tblrd_unit tblrd_unit_chk #(.PTR_W(PTR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ptr   (cmd_ptr),
  .rom_rd    (rom_rd),
  .busy      (busy),
  .done      (done),
  .a_we      (a_we),
  .b_we      (b_we),
  .d_q       (d_q),
  .mode_q    (mode_q)
);

// File: tb/tblrd_unit_tb_top.sv
module tblrd_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [6:0]  cmd_page;
  logic [2:0]  cmd_ptr;
  logic [3:0]  acc_in;
  logic        rom_rd;
  logic [13:0] rom_addr;
  logic [9:0]  rom_data;
  logic        busy, done, a_we, b_we, mode_q;
  logic [3:0]  a_wdata, b_wdata;
  logic [2:0]  d_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  tblrd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_ptr(cmd_ptr), .acc_in(acc_in),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .busy(busy), .done(done), .a_we(a_we), .a_wdata(a_wdata),
    .b_we(b_we), .b_wdata(b_wdata), .d_q(d_q), .mode_q(mode_q)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] rom_fn(input logic [13:0] a);
    logic [19:0] t;
    t = 20'(a) * 20'd37 + 20'(a >> 3);
    return t[9:0] ^ 10'h2A5;
  endfunction

  // ROM model, one cycle latency
  always @(posedge clk) if (rom_rd) rom_data <= rom_fn(rom_addr);

  // accumulator model owned by the bench
  logic [3:0] a_reg = 4'h9;
  always @(posedge clk) if (a_we) a_reg <= a_wdata;
  assign acc_in = a_reg;

  logic [2:0] d_model;
  bit         mode_model = 1'b0;

  typedef struct { logic [3:0] a; logic [3:0] b; logic [2:0] d; } exp_t;
  exp_t exp_q[$];
  logic [3:0] a_cap, b_cap;
  bit mon_on = 1'b0;

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (a_we) begin a_cap = a_wdata; b_cap = b_wdata; end
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(a_cap == e.a, "R3 A data", a_cap, e.a);
          check(b_cap == e.b, "R3 B data", b_cap, e.b);
          check(d_q == e.d, "R4/R5/R6 D after done", d_q, e.d);
        end
      end
    end
  end

  task automatic do_read(input logic [6:0] pg);
    logic [13:0] ea;
    logic [9:0]  w;
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_page = pg;
    #1;
    ea = {pg, d_model, a_reg};
    check(rom_rd == 1'b1, "R1 rom_rd", rom_rd, 1);
    check(rom_addr == ea, "R1 address", rom_addr, ea);
    w = rom_fn(ea);
    if (mode_model) d_model = {1'b0, w[9:8]};
    e.a = w[3:0]; e.b = w[7:4]; e.d = d_model;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2 busy", busy, 1);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [2:0] ptr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ptr = ptr;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'd2) mode_model = 1'b1;
    if (op == 3'd3) mode_model = 1'b0;
    if (op == 3'd4) d_model = ptr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_page = '0; cmd_ptr = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R10 busy/done reset", {busy, done}, 0);
    check(rom_rd == 0 && a_we == 0 && b_we == 0, "R10 strobes reset", {rom_rd, a_we, b_we}, 0);
    check(mode_q == 0, "R10 mode reset", mode_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    do_cmd(3'd4, 3'd5);
    check(d_q == 3'd5, "R8 load D", d_q, 5);

    // mode 0: D must hold
    do_read(7'h15);
    @(negedge clk);
    check(d_q == 3'd5, "R6 D held", d_q, 5);

    do_cmd(3'd2, 3'd0);
    check(mode_q == 1'b1, "R7 set mode", mode_q, 1);

    do_read(7'h7F);
    @(negedge clk);
    do_cmd(3'd4, 3'd7);
    do_read(7'h00);
    @(negedge clk);
    check(d_q[2] == 1'b0, "R5 D top cleared", d_q, d_model);

    // commands during busy are dropped
    do_read(7'h2A);
    cmd_valid = 1'b1; cmd_op = 3'd3;
    #1;
    check(rom_rd == 1'b0, "R9 no rom_rd in busy", rom_rd, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(mode_q == 1'b1, "R9 clear ignored", mode_q, 1);
    do_read(7'h31);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    #1;
    check(rom_rd == 1'b0, "R9 read ignored", rom_rd, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R9 no extra done", done, 0);

    do_cmd(3'd3, 3'd0);
    check(mode_q == 1'b0, "R7 clear mode", mode_q, 0);
    do_cmd(3'd4, 3'd6);
    do_read(7'h44);
    @(negedge clk);
    check(d_q == 3'd6, "R6 D held again", d_q, 6);

    // back-to-back chain in both modes
    for (int i = 0; i < 6; i++) do_read(7'(i * 19 + 3));
    do_cmd(3'd2, 3'd0);
    for (int i = 0; i < 6; i++) do_read(7'(i * 23 + 11));
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads completed", exp_q.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule